// File: doc/BRIEF.md
# Complex Parallel Matched-Filter Correlator

This block compresses received pulses by correlating a complex baseband sample stream against a short complex reference. The reference is the opening stretch of the transmitted linear-FM sweep. Each clock the block accepts `LANES` complex samples and returns `LANES` complex correlation results, so the filter keeps up with a stream that is wider than one sample per cycle. The result peaks when the most recent `NTAPS` input samples match the stored reference.

The complex product with the conjugated reference is formed from four real correlators over one shared sample history: I against the real coefficient part, Q against the imaginary part, I against the imaginary part, and Q against the real part. Their sums combine into the in-phase and quadrature outputs. A longer reference gives more processing gain and better rejection of interference. However, the real multiplier count is `4 * NTAPS * LANES`. The default build therefore holds 32 taps over two lanes, which comes to 256 multipliers.

Coefficients are written one tap at a time into a shadow bank through a plain address/data port. The shadow bank is copied into the working bank in one step on an input beat marked as the start of a frame. The output valid flag follows the input valid flag after a fixed three-cycle latency.

Top module: `mf_complex_correlator`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, both output buses are 0, and the sample history and both coefficient banks hold zeros.
- R2: `out_valid` is high exactly in the third cycle after each cycle in which `in_valid` was sampled high, and low otherwise. While `out_valid` is low, both output buses are 0.
- R3: Lane `l` occupies bits `[l*W +: W]` of its bus, where W is the lane width; lane 0 is the oldest sample of a beat. Sample n of the stream is x(n). The in-phase result for x(n) is the sum over k = 0..NTAPS-1 of `I(n-NTAPS+1+k)*cr[k] + Q(n-NTAPS+1+k)*ci[k]`. Samples before reset count as zero.
- R4: The quadrature result for x(n) is the sum over k of `Q(n-NTAPS+1+k)*cr[k] - I(n-NTAPS+1+k)*ci[k]`, with the same alignment as R3. Coefficient k = NTAPS-1 weights the newest sample.
- R5: When the last NTAPS samples equal the reference (x(n-NTAPS+1+k) = c[k]), the in-phase output equals the reference energy (the sum of cr² + ci²) and the quadrature output is 0.
- R6: A coefficient write (`cw_en` high, `cw_addr` selects tap k) changes only the shadow bank. The working bank takes the whole shadow bank on a beat with `in_valid` and `in_sof` both high, and that beat's outputs already use the new bank. Writes without such a beat leave every output unchanged.
- R7: Cycles with `in_valid` low do not advance the sample history. A stream with idle gaps yields the same results as the same samples sent back to back.
- R8: Outputs are full precision, with no rounding or wrap. The width is `DW + CW + clog2(NTAPS) + 1` bits signed, and extreme two's-complement inputs and coefficients give exact results.
- R9: A coefficient write in the same cycle as a frame-start beat goes to the shadow bank only. The working bank takes the shadow contents from before that write, and the written value takes effect at the following frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | clog2(NTAPS) | Tap index to write |
| cw_re | input | CW | Real part of coefficient, signed |
| cw_im | input | CW | Imaginary part of coefficient, signed |
| in_valid | input | 1 | Input beat present |
| in_sof | input | 1 | Beat is the first of a frame (commits the shadow bank) |
| in_i | input | LANES*DW | In-phase samples, lane 0 oldest |
| in_q | input | LANES*DW | Quadrature samples, lane 0 oldest |
| out_valid | output | 1 | Output beat present |
| out_i | output | LANES*(DW+CW+clog2(NTAPS)+1) | In-phase correlation per lane |
| out_q | output | LANES*(DW+CW+clog2(NTAPS)+1) | Quadrature correlation per lane |

## Verification
The bench first loads a reference and sends it as data. It checks for the energy peak with zero quadrature, which catches a missing conjugate, a swapped I/Q cross term or a reversed tap order. It writes coefficients without a frame start, and again in the same cycle as one. A design that commits writes at once, or commits after the pending write, then produces outputs built from the wrong bank. Idle gaps in the stream expose a history that shifts on every clock. Runs with all operands at the negative limit expose sums that are too narrow to hold the result, where outputs wrap to wrong signs.

// File: rtl/mf_pkg.sv
`timescale 1ns/1ps
// Package mf_pkg: shared width arithmetic for the matched-filter correlator.
// Assumes signed two's-complement data and coefficients throughout.
package mf_pkg;

    // Width of one real correlator sum: product width plus growth over the taps.
    function automatic int unsigned mf_sum_w(int unsigned dw, int unsigned cw, int unsigned ntaps);
        return dw + cw + $clog2(ntaps);
    endfunction

    // Width of a combined I or Q output: one more bit for the add/subtract.
    function automatic int unsigned mf_out_w(int unsigned dw, int unsigned cw, int unsigned ntaps);
        return dw + cw + $clog2(ntaps) + 1;
    endfunction

endpackage

// File: rtl/mf_coef_bank.sv
`timescale 1ns/1ps
// Module mf_coef_bank: double-buffered complex coefficient storage.
// Writes land in a shadow bank; on commit the whole shadow bank is copied
// into the working bank in one cycle. A write in the commit cycle reaches
// the shadow bank only, after the copy has taken the older contents.
// Assumes wr_addr values at or above NTAPS are meaningless and drops them.
module mf_coef_bank import mf_pkg::*; #(
    parameter int unsigned NTAPS = 32,
    parameter int unsigned CW    = 12,
    parameter int unsigned AW    = $clog2(NTAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [CW-1:0] wr_re,
    input  logic signed [CW-1:0] wr_im,
    input  logic                 commit,
    output logic signed [CW-1:0] act_re [NTAPS],
    output logic signed [CW-1:0] act_im [NTAPS]
);

    logic signed [CW-1:0] shd_re [NTAPS];
    logic signed [CW-1:0] shd_im [NTAPS];

    // Shadow bank: take single-tap writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) begin
                shd_re[k] <= '0;
                shd_im[k] <= '0;
            end
        end else if (wr_en && (32'(wr_addr) < NTAPS)) begin
            shd_re[wr_addr] <= wr_re;
            shd_im[wr_addr] <= wr_im;
        end
    end

    // Working bank: copy the full shadow bank at a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) begin
                act_re[k] <= '0;
                act_im[k] <= '0;
            end
        end else if (commit) begin
            for (int k = 0; k < NTAPS; k++) begin
                act_re[k] <= shd_re[k];
                act_im[k] <= shd_im[k];
            end
        end
    end

    AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_re[0]) && $stable(act_im[NTAPS-1]))); // R6

endmodule

// File: rtl/mf_sample_window.sv
`timescale 1ns/1ps
// Module mf_sample_window: sample history ordered by age.
// Slot 0 holds the newest sample (last lane of the latest beat); each
// accepted beat moves every sample LANES slots older. Nothing moves while
// shift_en is low. Assumes lane 0 of the input bus is the oldest sample.
module mf_sample_window #(
    parameter int unsigned LANES = 2,
    parameter int unsigned DW    = 12,
    parameter int unsigned HL    = 33
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   shift_en,
    input  logic [LANES*DW-1:0]    in_i,
    input  logic [LANES*DW-1:0]    in_q,
    output logic signed [DW-1:0]   hist_i [HL],
    output logic signed [DW-1:0]   hist_q [HL]
);

    for (genvar a = 0; a < HL; a++) begin : g_age
        if (a < LANES) begin : g_fresh
            // Load the youngest slots straight from the incoming beat.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_i[a] <= '0;
                    hist_q[a] <= '0;
                end else if (shift_en) begin
                    hist_i[a] <= in_i[(LANES-1-a)*DW +: DW];
                    hist_q[a] <= in_q[(LANES-1-a)*DW +: DW];
                end
            end
        end else begin : g_aged
            // Move older samples along by one beat.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_i[a] <= '0;
                    hist_q[a] <= '0;
                end else if (shift_en) begin
                    hist_i[a] <= hist_i[a-LANES];
                    hist_q[a] <= hist_q[a-LANES];
                end
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(hist_i[0]) && $stable(hist_q[HL-1]))); // R7

endmodule

// File: rtl/mf_real_dot.sv
`timescale 1ns/1ps
// Module mf_real_dot: one real correlator, sum of NTAPS signed products.
// Pure combinational; the caller registers the result. Assumes SW is at
// least DW+CW+clog2(NTAPS) so that the sum cannot wrap.
module mf_real_dot import mf_pkg::*; #(
    parameter int unsigned NTAPS = 32,
    parameter int unsigned DW    = 12,
    parameter int unsigned CW    = 12,
    parameter int unsigned SW    = mf_sum_w(DW, CW, NTAPS)
) (
    input  logic signed [DW-1:0] d [NTAPS],
    input  logic signed [CW-1:0] c [NTAPS],
    output logic signed [SW-1:0] sum
);

    localparam int unsigned PW = DW + CW;

    // Multiply each tap and accumulate at full width.
    always_comb begin
        logic signed [PW-1:0] prod;
        sum = '0;
        for (int k = 0; k < NTAPS; k++) begin
            prod = d[k] * c[k];
            sum  = sum + {{(SW-PW){prod[PW-1]}}, prod};
        end
    end

endmodule

// File: rtl/mf_complex_correlator.sv
`timescale 1ns/1ps
// Module mf_complex_correlator: parallel-lane complex matched filter.
// Correlates the stream with the conjugated reference using four real
// correlators per lane (I*cr, Q*ci, I*ci, Q*cr). Three register stages:
// history capture, real sums, complex combine. A beat with in_valid and
// in_sof commits the shadow coefficient bank; that beat already uses it.
// Assumes in_valid stays low during reset.
module mf_complex_correlator import mf_pkg::*; #(
    parameter  int unsigned LANES = 2,
    parameter  int unsigned NTAPS = 32,
    parameter  int unsigned DW    = 12,
    parameter  int unsigned CW    = 12,
    localparam int unsigned AW    = $clog2(NTAPS),
    localparam int unsigned OW    = mf_out_w(DW, CW, NTAPS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cw_en,
    input  logic [AW-1:0]         cw_addr,
    input  logic [CW-1:0]         cw_re,
    input  logic [CW-1:0]         cw_im,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic [LANES*DW-1:0]   in_i,
    input  logic [LANES*DW-1:0]   in_q,
    output logic                  out_valid,
    output logic [LANES*OW-1:0]   out_i,
    output logic [LANES*OW-1:0]   out_q
);

    localparam int unsigned SW = mf_sum_w(DW, CW, NTAPS);
    localparam int unsigned HL = NTAPS - 1 + LANES;

    logic                 commit;
    logic signed [CW-1:0] cr [NTAPS];
    logic signed [CW-1:0] ci [NTAPS];
    logic signed [DW-1:0] hist_i [HL];
    logic signed [DW-1:0] hist_q [HL];
    logic                 v1, v2;

    assign commit = in_valid && in_sof;

    mf_coef_bank #(.NTAPS(NTAPS), .CW(CW), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cw_en),
        .wr_addr (cw_addr),
        .wr_re   (cw_re),
        .wr_im   (cw_im),
        .commit  (commit),
        .act_re  (cr),
        .act_im  (ci)
    );

    mf_sample_window #(.LANES(LANES), .DW(DW), .HL(HL)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .hist_i   (hist_i),
        .hist_q   (hist_q)
    );

    // Valid pipeline matching the three data stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1        <= in_valid;
            v2        <= v1;
            out_valid <= v2;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [DW-1:0] di [NTAPS];
        logic signed [DW-1:0] dq [NTAPS];
        logic signed [SW-1:0] s_ir, s_qi, s_ii, s_qr;
        logic signed [SW-1:0] r_ir, r_qi, r_ii, r_qr;
        logic signed [OW-1:0] o_i, o_q;

        // Tap k sees the sample NTAPS-1-k older than this lane's own sample.
        for (genvar k = 0; k < NTAPS; k++) begin : g_tap
            assign di[k] = hist_i[LANES-1-l+NTAPS-1-k];
            assign dq[k] = hist_q[LANES-1-l+NTAPS-1-k];
        end

        mf_real_dot #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .SW(SW)) u_ir (.d(di), .c(cr), .sum(s_ir));
        mf_real_dot #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .SW(SW)) u_qi (.d(dq), .c(ci), .sum(s_qi));
        mf_real_dot #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .SW(SW)) u_ii (.d(di), .c(ci), .sum(s_ii));
        mf_real_dot #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .SW(SW)) u_qr (.d(dq), .c(cr), .sum(s_qr));

        // Register the four real sums of a captured beat.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_ir <= '0;
                r_qi <= '0;
                r_ii <= '0;
                r_qr <= '0;
            end else if (v1) begin
                r_ir <= s_ir;
                r_qi <= s_qi;
                r_ii <= s_ii;
                r_qr <= s_qr;
            end
        end

        // Combine into conjugate-correlation I and Q; zero when idle.
        always_ff @(posedge clk) begin
            if (!rst_n || !v2) begin
                o_i <= '0;
                o_q <= '0;
            end else begin
                o_i <= {r_ir[SW-1], r_ir} + {r_qi[SW-1], r_qi};
                o_q <= {r_qr[SW-1], r_qr} - {r_ii[SW-1], r_ii};
            end
        end

        assign out_i[l*OW +: OW] = o_i;
        assign out_q[l*OW +: OW] = o_q;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3)); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_i == '0 && out_q == '0)); // R2

endmodule

// File: tb/mf_complex_correlator_tb_top.sv
`timescale 1ns/1ps
// Directed bench for mf_complex_correlator with an independent reference model.
module mf_complex_correlator_tb_top;

    localparam int unsigned LANES = 2;
    localparam int unsigned NTAPS = 32;
    localparam int unsigned DW    = 12;
    localparam int unsigned CW    = 12;
    localparam int unsigned AW    = $clog2(NTAPS);
    localparam int unsigned OW    = DW + CW + $clog2(NTAPS) + 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst_n = 1'b0;
    logic                cw_en = 1'b0;
    logic [AW-1:0]       cw_addr = '0;
    logic [CW-1:0]       cw_re = '0, cw_im = '0;
    logic                in_valid = 1'b0, in_sof = 1'b0;
    logic [LANES*DW-1:0] in_i = '0, in_q = '0;
    logic                out_valid;
    logic [LANES*OW-1:0] out_i, out_q;

    mf_complex_correlator #(.LANES(LANES), .NTAPS(NTAPS), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_addr(cw_addr),
        .cw_re(cw_re), .cw_im(cw_im), .in_valid(in_valid), .in_sof(in_sof),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int m_cr [NTAPS], m_ci [NTAPS];   // model working bank
    int s_cr [NTAPS], s_ci [NTAPS];   // model shadow bank
    int mi[$], mq[$];                 // every sample accepted since reset
    longint exp_i[$], exp_q[$];
    string  exp_tag[$];
    string  mon_tag;
    longint mon_ei, mon_eq, mon_ai, mon_aq;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Reference: conjugate correlation ending at stream sample n.
    function automatic void model_out(input int n, output longint ei, output longint eq);
        ei = 0;
        eq = 0;
        for (int k = 0; k < NTAPS; k++) begin
            int idx = n - NTAPS + 1 + k;
            if (idx >= 0) begin
                ei += longint'(mi[idx]) * m_cr[k] + longint'(mq[idx]) * m_ci[k];
                eq += longint'(mq[idx]) * m_cr[k] - longint'(mi[idx]) * m_ci[k];
            end
        end
    endfunction

    // Output monitor: compare every valid beat with the model, lane by lane.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_tag.size() == 0) begin
                check(1'b0, "R2", "out_valid with no beat pending", 1, 0);
            end else begin
                mon_tag = exp_tag.pop_front();
                for (int l = 0; l < LANES; l++) begin
                    mon_ei = exp_i.pop_front();
                    mon_eq = exp_q.pop_front();
                    mon_ai = longint'($signed(out_i[l*OW +: OW]));
                    mon_aq = longint'($signed(out_q[l*OW +: OW]));
                    check(mon_ai == mon_ei, mon_tag, $sformatf("lane %0d I", l), mon_ai, mon_ei);
                    check(mon_aq == mon_eq, mon_tag, $sformatf("lane %0d Q", l), mon_aq, mon_eq);
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; cw_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mi.delete(); mq.delete(); exp_i.delete(); exp_q.delete(); exp_tag.delete();
        for (int k = 0; k < NTAPS; k++) begin
            m_cr[k] = 0; m_ci[k] = 0; s_cr[k] = 0; s_ci[k] = 0;
        end
    endtask

    task automatic write_coef(input int addr, input int re, input int im);
        cw_en = 1'b1; cw_addr = AW'(addr); cw_re = CW'(re); cw_im = CW'(im);
        s_cr[addr] = re; s_ci[addr] = im;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    // One beat; optional coefficient write in the same cycle.
    task automatic send_beat(input bit sof, input int si[LANES], input int sq[LANES],
                             input string tag, input bit wr = 1'b0, input int waddr = 0,
                             input int wre = 0, input int wim = 0);
        longint ei, eq;
        in_valid = 1'b1; in_sof = sof;
        for (int l = 0; l < LANES; l++) begin
            in_i[l*DW +: DW] = DW'(si[l]);
            in_q[l*DW +: DW] = DW'(sq[l]);
        end
        cw_en = wr; cw_addr = AW'(waddr); cw_re = CW'(wre); cw_im = CW'(wim);
        if (sof) begin
            for (int k = 0; k < NTAPS; k++) begin m_cr[k] = s_cr[k]; m_ci[k] = s_ci[k]; end
        end
        if (wr) begin s_cr[waddr] = wre; s_ci[waddr] = wim; end
        for (int l = 0; l < LANES; l++) begin mi.push_back(si[l]); mq.push_back(sq[l]); end
        for (int l = 0; l < LANES; l++) begin
            model_out(mi.size() - LANES + l, ei, eq);
            exp_i.push_back(ei);
            exp_q.push_back(eq);
        end
        exp_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; cw_en = 1'b0;
    endtask

    task automatic send_random(input bit sof, input int lim, input string tag);
        int si[LANES], sq[LANES];
        for (int l = 0; l < LANES; l++) begin
            si[l] = $urandom_range(0, 2*lim) - lim;
            sq[l] = $urandom_range(0, 2*lim) - lim;
        end
        send_beat(sof, si, sq, tag);
    endtask

    task automatic drain(input string tag);
        repeat (5) @(negedge clk);
        check(exp_tag.size() == 0, tag, "beats still pending", exp_tag.size(), 0);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(out_i == '0 && out_q == '0, "R1", "outputs after reset",
              longint'($signed(out_i[OW-1:0])), 0);
    endtask

    task automatic t_latency();
        int si[LANES], sq[LANES];
        for (int k = 0; k < NTAPS; k++) write_coef(k, k - 16, 3 - k);
        for (int l = 0; l < LANES; l++) begin si[l] = 100 + l; sq[l] = -50 - l; end
        send_beat(1'b1, si, sq, "R2");
        check(out_valid == 1'b0, "R2", "out_valid one cycle after beat", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R2", "out_valid two cycles after beat", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R2", "out_valid three cycles after beat", out_valid, 1);
        @(negedge clk);
        check(out_valid == 1'b0, "R2", "out_valid after single beat", out_valid, 0);
        check(out_i == '0 && out_q == '0, "R2", "idle outputs zero",
              longint'($signed(out_i[OW-1:0])), 0);
        drain("R2");
    endtask

    task automatic t_random();
        for (int k = 0; k < NTAPS; k++)
            write_coef(k, $urandom_range(0, 4095) - 2048, $urandom_range(0, 4095) - 2048);
        for (int b = 0; b < 40; b++) send_random(b == 0, 2048, "R3/R4");
        drain("R3/R4");
    endtask

    task automatic t_peak();
        int ref_i[NTAPS], ref_q[NTAPS];
        longint energy = 0;
        int si[LANES], sq[LANES];
        for (int k = 0; k < NTAPS; k++) begin
            ref_i[k] = $urandom_range(0, 2000) - 1000;
            ref_q[k] = $urandom_range(0, 2000) - 1000;
            energy += longint'(ref_i[k]) * ref_i[k] + longint'(ref_q[k]) * ref_q[k];
            write_coef(k, ref_i[k], ref_q[k]);
        end
        for (int b = 0; b < NTAPS / LANES; b++) begin
            for (int l = 0; l < LANES; l++) begin
                si[l] = ref_i[b*LANES + l];
                sq[l] = ref_q[b*LANES + l];
            end
            send_beat(b == 0, si, sq, "R5");
        end
        // Peak lands on the last lane of the last beat: energy on I, zero on Q.
        exp_i[exp_i.size()-1] = energy;
        exp_q[exp_q.size()-1] = 0;
        drain("R5");
    endtask

    task automatic t_gaps();
        for (int b = 0; b < 20; b++) begin
            send_random(1'b0, 2048, "R7");
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        drain("R7");
    endtask

    task automatic t_shadow();
        for (int k = 0; k < NTAPS; k++) write_coef(k, 500 - 30*k, 20*k - 300);
        send_random(1'b1, 1500, "R6");
        // New bank written without a frame start: outputs must still use the old one.
        for (int k = 0; k < NTAPS; k++) write_coef(k, -700 + 40*k, 900 - 25*k);
        for (int b = 0; b < 5; b++) send_random(1'b0, 1500, "R6");
        // Write to the newest-sample tap in the commit cycle itself.
        begin
            int si[LANES], sq[LANES];
            for (int l = 0; l < LANES; l++) begin si[l] = 1200 - l; sq[l] = -800 + l; end
            send_beat(1'b1, si, sq, "R9", 1'b1, NTAPS-1, 2000, -2000);
        end
        for (int b = 0; b < 4; b++) send_random(1'b0, 1500, "R9");
        send_random(1'b1, 1500, "R9");
        for (int b = 0; b < 3; b++) send_random(1'b0, 1500, "R9");
        drain("R6/R9");
    endtask

    task automatic t_extreme();
        int si[LANES], sq[LANES];
        for (int k = 0; k < NTAPS; k++) write_coef(k, -2048, -2048);
        for (int l = 0; l < LANES; l++) begin si[l] = -2048; sq[l] = -2048; end
        for (int b = 0; b < NTAPS / LANES; b++) send_beat(b == 0, si, sq, "R8");
        for (int k = 0; k < NTAPS; k++) write_coef(k, -2048, 2047);
        for (int l = 0; l < LANES; l++) begin si[l] = 2047; sq[l] = -2048; end
        for (int b = 0; b < NTAPS / LANES; b++) send_beat(b == 0, si, sq, "R8");
        drain("R8");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_random();
        t_peak();
        t_gaps();
        t_shadow();
        t_extreme();
        finished = 1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule